// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pull-ups

This block is an eight-bit general-purpose I/O port on a simple register bus. The bus has an address, a write strobe with write data, and a read strobe with read data. The port holds two registers: an output value latch and a direction register. It also offers a read-only view of the live pin levels. For every pin it presents three signals to a tri-state pad: a drive value, a drive enable and a weak pull-up enable.

A pin whose direction bit is set drives its latch bit. A pin whose direction bit is clear is an input. On an input pin the latch bit takes a second role: writing a one to it turns on the weak pull-up. Reading the latch address returns what software last wrote there. Reading the pin address returns the synchronised level actually present on the pads. Reset acts asynchronously on the pad controls, so the pins float as soon as reset is applied, whether or not the clock is running.

Top module: `gpio_port`

## Requirements
- R1: While rst_n is low, pad_oe, pad_pu and pad_out are all zero, without waiting for any clock edge. After reset, the latch and direction registers read back as 0x00.
- R2: A write with bus_wr high to address 0x12 loads bus_wdata into the output latch on the rising clock edge. A later read of 0x12 returns that value.
- R3: A write with bus_wr high to address 0x11 loads bus_wdata into the direction register on the rising clock edge. A later read of 0x11 returns that value.
- R4: A read of address 0x10 returns pad_in after two register stages. A change on pad_in appears in the read data only after two rising clock edges.
- R5: A write to address 0x10 changes neither register, so pad_out and pad_oe do not move.
- R6: For each pin, pad_out equals its latch bit and pad_oe equals its direction bit (1 = output).
- R7: For each pin, pad_pu is high exactly when its direction bit is 0 and its latch bit is 1. pad_pu and pad_oe are never both high on the same pin.
- R8: A read of 0x12 returns the latch contents even when the pin levels differ from them.
- R9: A read of any address other than 0x10, 0x11 or 0x12 returns 0x00. A write to such an address changes no register.
- R10: bus_rdata is 0x00 whenever bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pad_in | input | 8 | Level seen on each pin |
| pad_out | output | 8 | Drive value per pin |
| pad_oe | output | 8 | Drive enable per pin |
| pad_pu | output | 8 | Weak pull-up enable per pin |

## Verification
The clocked assertions assume that bus_addr, bus_wr and bus_wdata are stable around each rising edge. They also assume the pad inputs are known values and not X. The bench changes every bus signal and every external pin level one time unit after a rising edge, and it samples at the falling edge. It models the pad as the port's driver, then an optional external driver, then the pull-up, with a low default. Because of this, pad_in is always a defined level.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int WIDTH       = 8,
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [AW-1:0] ADDR_PIN = 8'h10,
  parameter logic [AW-1:0] ADDR_DIR = 8'h11,
  parameter logic [AW-1:0] ADDR_OUT = 8'h12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [WIDTH-1:0] bus_wdata,
  input  logic             bus_rd,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu
);

  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] out_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] sync_q [SYNC_STAGES];
  logic [WIDTH-1:0] pin_lvl;
  logic [WIDTH-1:0] rst_mask;

  wire hit_out = bus_addr == ADDR_OUT;
  wire hit_dir = bus_addr == ADDR_DIR;
  wire hit_pin = bus_addr == ADDR_PIN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= ZERO;
      dir_q <= ZERO;
    end else if (bus_wr) begin
      if (hit_out) out_q <= bus_wdata;
      if (hit_dir) dir_q <= bus_wdata;
    end
  end

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= ZERO;
        else if (s == 0) sync_q[s] <= pad_in;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign pin_lvl = sync_q[SYNC_STAGES-1];

  always_comb begin
    bus_rdata = ZERO;
    if (bus_rd) begin
      if (hit_out)      bus_rdata = out_q;
      else if (hit_dir) bus_rdata = dir_q;
      else if (hit_pin) bus_rdata = pin_lvl;
    end
  end

  assign rst_mask = {WIDTH{rst_n}};
  assign pad_out  = out_q & rst_mask;
  assign pad_oe   = dir_q & rst_mask;
  assign pad_pu   = ~dir_q & out_q & rst_mask;

  always_comb begin
    if (rst_n == 1'b0)
      a_r1_reset_float: assert ((pad_oe | pad_pu | pad_out) == ZERO);
  end

  a_r2_out_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_out) |=> pad_out == $past(bus_wdata));

  a_r3_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_dir) |=> pad_oe == $past(bus_wdata));

  a_r5_pin_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_pin) |=> ($stable(pad_out) && $stable(pad_oe)));

  a_r7_pu_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == ZERO);

  a_r9_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit_out && !hit_dir) |=> ($stable(pad_out) && $stable(pad_oe)));

  a_r10_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == ZERO);

endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] bus_addr = 0;
  logic       bus_wr = 0;
  logic [7:0] bus_wdata = 0;
  logic       bus_rd = 0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in;
  logic [7:0] pad_out, pad_oe, pad_pu;
  logic [7:0] ext_en = 0;
  logic [7:0] ext_val = 0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // Pad model: own driver, then external driver, then pull-up, else low.
  always_comb
    for (int i = 0; i < 8; i++)
      pad_in[i] = pad_oe[i] ? pad_out[i] : ext_en[i] ? ext_val[i] : pad_pu[i];

  gpio_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard at each falling edge with a read in progress.
  always @(negedge clk) begin
    if (bus_rd) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard actual=%h expected=none", bus_rdata);
      end else begin
        check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1;
    @(posedge clk); #1;
    bus_rd = 0;
  endtask

  task automatic pads(input logic [7:0] o, input logic [7:0] e, input logic [7:0] p, input string tag);
    check(pad_out, o, {tag, " pad_out"});
    check(pad_oe, e, {tag, " pad_oe"});
    check(pad_pu, p, {tag, " pad_pu"});
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #3;
    pads(8'h00, 8'h00, 8'h00, "R1 in reset");
    idle(2);
    rst_n = 1;
    idle(1);
    rd(8'h12, 8'h00, "R1 latch after reset");
    rd(8'h11, 8'h00, "R1 dir after reset");

    wr(8'h12, 8'hA5);
    rd(8'h12, 8'hA5, "R2 latch readback");
    wr(8'h11, 8'h0F);
    rd(8'h11, 8'h0F, "R3 dir readback");
    pads(8'hA5, 8'h0F, 8'hA0, "R6 R7 mixed");

    wr(8'h12, 8'h3C);
    pads(8'h3C, 8'h0F, 8'h30, "R7 latch change");
    wr(8'h11, 8'hFF);
    pads(8'h3C, 8'hFF, 8'h00, "R7 all outputs");
    wr(8'h11, 8'h00);
    pads(8'h3C, 8'h00, 8'h3C, "R7 all inputs");

    wr(8'h10, 8'hFF);
    pads(8'h3C, 8'h00, 8'h3C, "R5 pin write ignored");
    rd(8'h12, 8'h3C, "R5 latch intact");
    rd(8'h11, 8'h00, "R5 dir intact");

    // External driver overrides pull-ups; pins differ from latch.
    ext_en = 8'hF0; ext_val = 8'h50;
    idle(3);
    rd(8'h10, 8'h5C, "R4 pins settled");
    rd(8'h12, 8'h3C, "R8 latch not pins");

    // Latency: change pins, expect old value for two edges.
    ext_val = 8'hA0;
    rd(8'h10, 8'h5C, "R4 latency edge0");
    rd(8'h10, 8'h5C, "R4 latency edge1");
    rd(8'h10, 8'hAC, "R4 latency edge2");

    ext_en = 8'h00;
    wr(8'h11, 8'hC3);
    wr(8'h12, 8'h81);
    idle(3);
    // outputs C3 drive 81 -> bits 7,0 high; inputs 3C with latch 00 -> low
    rd(8'h10, 8'h81, "R4 driven pins");

    wr(8'h20, 8'hFF);
    wr(8'h00, 8'hFF);
    rd(8'h20, 8'h00, "R9 unmapped read");
    rd(8'hFF, 8'h00, "R9 unmapped read high");
    rd(8'h12, 8'h81, "R9 latch intact");
    rd(8'h11, 8'hC3, "R9 dir intact");

    bus_addr = 8'h12; bus_rd = 0;
    #2;
    check(bus_rdata, 8'h00, "R10 idle read");
    idle(1);

    // Asynchronous reset between edges.
    #2 rst_n = 0;
    #1 pads(8'h00, 8'h00, 8'h00, "R1 async reset");
    idle(1);
    rst_n = 1;
    idle(1);
    rd(8'h11, 8'h00, "R1 dir cleared");
    idle(1);

    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard actual=%0d expected=0 leftover", exp_q.size());
    end
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule